// File: doc/BRIEF.md
# Multiplexed MDIO Management Master

This block is a management-interface master that runs one Clause 22 or Clause 45 read or write at a time. A single serial engine serves several MDIO buses. Some buses are internal and the rest are external. Software programs the job through a 32-bit register interface. It writes a parameter word (bus selection, PHY address, write data, Clause 45 flag) and then the register address. It then starts the job with a command write to the control register and polls the completion flag in the status register. When a read completes, the received 16-bit value is returned in the read-data register.

The MDC half-period comes from a rate register. Jobs on internal buses use one rate register and jobs on external buses use the other. Only the selected bus toggles: its MDC runs, and its MDIO is driven with a per-bus output enable. All other buses stay idle, with MDC low and MDIO released. External buses drive their pins only while the ownership-override bit in the scan-control register is set.

Top module: `mdio_mux_master`

## Requirements
- R1: After reset every register reads 0, the status done bit is 0, and all MDC outputs and MDIO output enables are low.
- R2: The register offsets are: external rate 0x000, internal rate 0x004, scan control 0x008, parameter 0x23C, read data 0x240, address 0x244, control 0x248, status 0x24C. A rate register reads back as divisor [9:0] and dividend [21:16]. Scan control reads back only bit 28. Parameter and address read back all 32 bits. A write to read data has no effect.
- R3: The parameter word holds write data [15:0], PHY address [20:16], Clause 45 flag [21], bus id [24:22] and internal select [25]. Internal select 1 picks internal bus `id` and 0 picks external bus `id`, which is pin index 4+id with the default sizes. An id beyond the bus count selects no pins. At most one bus ever toggles, and unselected buses keep MDC low and output enable low.
- R4: A Clause 22 frame is 32 ones, start 01, opcode 01 (write) or 10 (read), 5-bit PHY address, address bits [4:0], turnaround 10, and 16 data bits. Each field is sent MSB first.
- R5: On a read, output enable is low for the 2 turnaround bits and the 16 data bits. The data is sampled on MDC rising edges, MSB first, and appears in read-data bits [15:0] when the job completes.
- R6: With the Clause 45 flag set, an address frame (start 00, opcode 00, device = address bits [20:16], data = address bits [15:0]) is sent first. It is followed by a second frame with start 00, opcode 01 (write) or 11 (read), and the same device field.
- R7: Each MDC half-period lasts max(divisor,1)*(dividend+1) clock cycles. Internal jobs use the internal rate register and external jobs use the external one. MDIO never changes on an MDC rising edge.
- R8: Control write value 1 starts a write, 2 starts a read, and 0 clears done. Value 3 has no effect. A start while a job is running is ignored. An accepted start clears done.
- R9: Done becomes 1 in the cycle of the last MDC falling edge of the job, stays 1 until cleared or restarted, and wins over a clear written in that same cycle.
- R10: While scan-control bit 28 is 0, jobs on external buses keep their pins idle but still complete and set done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on reg_addr_i |
| mdc_o | output | N_INT+N_EXT | MDC per bus |
| mdio_o | output | N_INT+N_EXT | MDIO output value per bus |
| mdio_oe_o | output | N_INT+N_EXT | MDIO output enable per bus |
| mdio_i | input | N_INT+N_EXT | MDIO input per bus |

## Verification
Two functions can land in the same clock edge: the completion of a job, which sets done on the final MDC fall, and a software clear written to the control register. The bench runs a write at the fastest rate and counts MDC rising edges on the selected bus. It times the clear write so that it registers on the edge where the 64th bit ends, then checks that done reads 1. A second collision, a new start arriving while a job is still shifting, is judged by confirming that the captured frame is still the original write frame and that it has exactly 64 bits.

// File: rtl/mdio_mux_pkg.sv
package mdio_mux_pkg;
  localparam logic [11:0] OFS_EXT_RATE = 12'h000;
  localparam logic [11:0] OFS_INT_RATE = 12'h004;
  localparam logic [11:0] OFS_SCAN     = 12'h008;
  localparam logic [11:0] OFS_PARAM    = 12'h23C;
  localparam logic [11:0] OFS_RDATA    = 12'h240;
  localparam logic [11:0] OFS_ADDR     = 12'h244;
  localparam logic [11:0] OFS_CTRL     = 12'h248;
  localparam logic [11:0] OFS_STAT     = 12'h24C;

  localparam int OWN_BIT = 28;
  localparam int INT_BIT = 25;
  localparam int C45_BIT = 21;
  localparam int RATE_HI = 16;

  localparam logic [1:0] CMD_CLR = 2'd0;
  localparam logic [1:0] CMD_WR  = 2'd1;
  localparam logic [1:0] CMD_RD  = 2'd2;

  typedef struct packed {
    logic        rd;
    logic        c45;
    logic        int_sel;
    logic [2:0]  bus_id;
    logic [4:0]  phy;
    logic [15:0] wdata;
    logic [20:0] addr;
  } job_t;

  function automatic logic [63:0] mk_frame(logic [1:0] st, logic [1:0] op,
                                           logic [4:0] pa, logic [4:0] ra,
                                           logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
  endfunction
endpackage

// File: rtl/mdio_mux_regs.sv
module mdio_mux_regs
  import mdio_mux_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int DVD_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [11:0]      addr_i,
  input  logic [31:0]      wdata_i,
  input  logic             busy_i,
  input  logic             fin_i,
  input  logic [15:0]      rd16_i,
  output logic [31:0]      rdata_o,
  output logic             start_o,
  output job_t             job_o,
  output logic [DIV_W-1:0] int_div_o,
  output logic [DVD_W-1:0] int_dvd_o,
  output logic [DIV_W-1:0] ext_div_o,
  output logic [DVD_W-1:0] ext_dvd_o,
  output logic             own_o,
  output logic             done_o
);
  logic [DIV_W-1:0] ext_div_q, int_div_q;
  logic [DVD_W-1:0] ext_dvd_q, int_dvd_q;
  logic             own_q, done_q;
  logic [31:0]      param_q, addr_q;
  logic             ctrl_wr, clr;

  assign ctrl_wr = wr_i && (addr_i == OFS_CTRL);
  assign clr     = ctrl_wr && (wdata_i[1:0] == CMD_CLR);
  assign start_o = ctrl_wr && !busy_i &&
                   (wdata_i[1:0] == CMD_WR || wdata_i[1:0] == CMD_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_div_q <= '0;
      ext_dvd_q <= '0;
      int_div_q <= '0;
      int_dvd_q <= '0;
      own_q     <= 1'b0;
      param_q   <= '0;
      addr_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      if (wr_i) begin
        case (addr_i)
          OFS_EXT_RATE: begin
            ext_div_q <= wdata_i[DIV_W-1:0];
            ext_dvd_q <= wdata_i[RATE_HI +: DVD_W];
          end
          OFS_INT_RATE: begin
            int_div_q <= wdata_i[DIV_W-1:0];
            int_dvd_q <= wdata_i[RATE_HI +: DVD_W];
          end
          OFS_SCAN:  own_q   <= wdata_i[OWN_BIT];
          OFS_PARAM: param_q <= wdata_i;
          OFS_ADDR:  addr_q  <= wdata_i;
          default: ;
        endcase
      end
      // completion outranks a clear in the same cycle
      if (fin_i)        done_q <= 1'b1;
      else if (clr)     done_q <= 1'b0;
      else if (start_o) done_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_EXT_RATE: rdata_o = 32'(ext_div_q) | (32'(ext_dvd_q) << RATE_HI);
      OFS_INT_RATE: rdata_o = 32'(int_div_q) | (32'(int_dvd_q) << RATE_HI);
      OFS_SCAN:     rdata_o = 32'(own_q) << OWN_BIT;
      OFS_PARAM:    rdata_o = param_q;
      OFS_RDATA:    rdata_o = {16'h0, rd16_i};
      OFS_ADDR:     rdata_o = addr_q;
      OFS_STAT:     rdata_o = {31'h0, done_q};
      default:      rdata_o = '0;
    endcase
  end

  always_comb begin
    job_o.rd      = (wdata_i[1:0] == CMD_RD);
    job_o.c45     = param_q[C45_BIT];
    job_o.int_sel = param_q[INT_BIT];
    job_o.bus_id  = param_q[24:22];
    job_o.phy     = param_q[20:16];
    job_o.wdata   = param_q[15:0];
    job_o.addr    = addr_q[20:0];
  end

  assign int_div_o = int_div_q;
  assign int_dvd_o = int_dvd_q;
  assign ext_div_o = ext_div_q;
  assign ext_dvd_o = ext_dvd_q;
  assign own_o     = own_q;
  assign done_o    = done_q;
endmodule

// File: rtl/mdio_mux_clkgen.sv
module mdio_mux_clkgen #(
  parameter int DIV_W = 10,
  parameter int DVD_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DVD_W-1:0] dvd_i,
  output logic             tick_o
);
  localparam int HW = DIV_W + DVD_W + 1;

  logic [HW-1:0] half_len, cnt_q;
  logic [DIV_W-1:0] div_eff;

  assign div_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
  assign half_len = HW'(div_eff) * (HW'(dvd_i) + HW'(1));
  assign tick_o   = en_i && (cnt_q == half_len - HW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + HW'(1);
  end
endmodule

// File: rtl/mdio_mux_engine.sv
module mdio_mux_engine
  import mdio_mux_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  job_t        job_i,
  input  logic        tick_i,
  input  logic        din_i,
  output logic        busy_o,
  output logic        fin_o,
  output logic        mdc_o,
  output logic        mdo_o,
  output logic        oe_o,
  output logic [15:0] rdata_o,
  output job_t        job_o
);
  logic        busy_q, mdc_q, second_q;
  logic [5:0]  bit_q;
  logic [63:0] sh_q;
  logic [15:0] rsh_q, rd_q;
  job_t        job_q;
  logic        rd_frame, last_frame;

  function automatic logic [63:0] first_frame(job_t j);
    if (j.c45) return mk_frame(2'b00, 2'b00, j.phy, j.addr[20:16], j.addr[15:0]);
    return mk_frame(2'b01, j.rd ? 2'b10 : 2'b01, j.phy, j.addr[4:0],
                    j.rd ? 16'hFFFF : j.wdata);
  endfunction

  function automatic logic [63:0] second_frame(job_t j);
    return mk_frame(2'b00, j.rd ? 2'b11 : 2'b01, j.phy, j.addr[20:16],
                    j.rd ? 16'hFFFF : j.wdata);
  endfunction

  assign last_frame = !job_q.c45 || second_q;
  assign rd_frame   = job_q.rd && last_frame;
  assign fin_o      = busy_q && tick_i && mdc_q && (bit_q == 6'd63) && last_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      mdc_q    <= 1'b0;
      second_q <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
      rsh_q    <= '0;
      rd_q     <= '0;
      job_q    <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      mdc_q    <= 1'b0;
      second_q <= 1'b0;
      bit_q    <= '0;
      job_q    <= job_i;
      sh_q     <= first_frame(job_i);
    end else if (busy_q && tick_i) begin
      if (!mdc_q) begin
        mdc_q <= 1'b1;
        if (rd_frame && bit_q >= 6'd48) rsh_q <= {rsh_q[14:0], din_i};
      end else begin
        mdc_q <= 1'b0;
        if (bit_q == 6'd63) begin
          bit_q <= '0;
          if (!last_frame) begin
            second_q <= 1'b1;
            sh_q     <= second_frame(job_q);
          end else begin
            busy_q <= 1'b0;
            if (job_q.rd) rd_q <= rsh_q;
          end
        end else begin
          bit_q <= bit_q + 6'd1;
          sh_q  <= {sh_q[62:0], 1'b0};
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign mdc_o   = mdc_q;
  assign mdo_o   = sh_q[63];
  assign oe_o    = busy_q && !(rd_frame && bit_q >= 6'd46);
  assign rdata_o = rd_q;
  assign job_o   = job_q;
endmodule

// File: rtl/mdio_mux_pins.sv
module mdio_mux_pins #(
  parameter int N_INT = 4,
  parameter int N_EXT = 4,
  localparam int NB   = N_INT + N_EXT
) (
  input  logic          busy_i,
  input  logic          int_sel_i,
  input  logic [2:0]    bus_id_i,
  input  logic          own_i,
  input  logic          mdc_i,
  input  logic          mdo_i,
  input  logic          oe_i,
  input  logic [NB-1:0] din_i,
  output logic [NB-1:0] mdc_o,
  output logic [NB-1:0] mdio_o,
  output logic [NB-1:0] mdio_oe_o,
  output logic          din_o
);
  logic [NB-1:0] hit;

  for (genvar g = 0; g < NB; g++) begin : g_bus
    localparam bit IS_INT = (g < N_INT);
    localparam int ID     = IS_INT ? g : g - N_INT;
    assign hit[g]       = busy_i && (int_sel_i == IS_INT) && (bus_id_i == 3'(ID)) &&
                          (IS_INT || own_i);
    assign mdc_o[g]     = hit[g] & mdc_i;
    assign mdio_oe_o[g] = hit[g] & oe_i;
    assign mdio_o[g]    = hit[g] & oe_i & mdo_i;
  end

  assign din_o = |(hit & din_i);
endmodule

// File: rtl/mdio_mux_master.sv
module mdio_mux_master
  import mdio_mux_pkg::*;
#(
  parameter int N_INT = 4,
  parameter int N_EXT = 4,
  parameter int DIV_W = 10,
  parameter int DVD_W = 6,
  localparam int NBUS = N_INT + N_EXT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_wr_i,
  input  logic [11:0]     reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  output logic [NBUS-1:0] mdc_o,
  output logic [NBUS-1:0] mdio_o,
  output logic [NBUS-1:0] mdio_oe_o,
  input  logic [NBUS-1:0] mdio_i
);
  logic             start_w, busy_w, fin_w, done_w, tick_w, own_w;
  logic             mdc_w, mdo_w, oe_w, din_w;
  logic [15:0]      rd16_w;
  job_t             new_job, cur_job;
  logic [DIV_W-1:0] int_div, ext_div, div_sel;
  logic [DVD_W-1:0] int_dvd, ext_dvd, dvd_sel;

  mdio_mux_regs #(.DIV_W(DIV_W), .DVD_W(DVD_W)) regs_i (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy_w), .fin_i(fin_w), .rd16_i(rd16_w),
    .rdata_o(reg_rdata_o), .start_o(start_w), .job_o(new_job),
    .int_div_o(int_div), .int_dvd_o(int_dvd),
    .ext_div_o(ext_div), .ext_dvd_o(ext_dvd),
    .own_o(own_w), .done_o(done_w)
  );

  assign div_sel = cur_job.int_sel ? int_div : ext_div;
  assign dvd_sel = cur_job.int_sel ? int_dvd : ext_dvd;

  mdio_mux_clkgen #(.DIV_W(DIV_W), .DVD_W(DVD_W)) clkgen_i (
    .clk_i, .rst_ni, .en_i(busy_w), .div_i(div_sel), .dvd_i(dvd_sel), .tick_o(tick_w)
  );

  mdio_mux_engine engine_i (
    .clk_i, .rst_ni, .start_i(start_w), .job_i(new_job), .tick_i(tick_w),
    .din_i(din_w), .busy_o(busy_w), .fin_o(fin_w), .mdc_o(mdc_w),
    .mdo_o(mdo_w), .oe_o(oe_w), .rdata_o(rd16_w), .job_o(cur_job)
  );

  mdio_mux_pins #(.N_INT(N_INT), .N_EXT(N_EXT)) pins_i (
    .busy_i(busy_w), .int_sel_i(cur_job.int_sel), .bus_id_i(cur_job.bus_id),
    .own_i(own_w), .mdc_i(mdc_w), .mdo_i(mdo_w), .oe_i(oe_w), .din_i(mdio_i),
    .mdc_o, .mdio_o, .mdio_oe_o, .din_o(din_w)
  );
endmodule

// File: rtl/mdio_mux_master_chk.sv
module mdio_mux_master_chk #(
  parameter int NB = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NB-1:0] mdc_o,
  input logic [NB-1:0] mdio_o,
  input logic [NB-1:0] mdio_oe_o,
  input logic          busy_w,
  input logic          done_w,
  input logic          start_w
);
  AST_ONE_MDC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mdc_o)); // R3
  AST_ONE_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mdio_oe_o)); // R3
  AST_HOLD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|mdc_o) |-> ($stable(mdio_o) && $stable(mdio_oe_o))); // R7
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> busy_w); // R8
  AST_BUSY_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_w |-> !done_w); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w |-> (mdc_o == '0 && mdio_oe_o == '0)); // R9
endmodule

bind mdio_mux_master mdio_mux_master_chk #(.NB(NBUS)) chk_i (
  .clk_i, .rst_ni, .mdc_o, .mdio_o, .mdio_oe_o,
  .busy_w(busy_w), .done_w(done_w), .start_w(start_w)
);

// File: tb/mdio_mux_master_tb_top.sv
module mdio_mux_master_tb_top;
  localparam int NI = 4, NE = 4, NB = 8;
  localparam logic [11:0] A_EXT = 12'h000, A_INT = 12'h004, A_SCAN = 12'h008,
    A_PAR = 12'h23C, A_RD = 12'h240, A_ADR = 12'h244, A_CTL = 12'h248, A_ST = 12'h24C;
  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] RD_OE = 64'hFFFF_FFFF_FFFC_0000;
  // {c45, rd, int_sel, bus_id[3], phy[5], addr[32], wdata[16], phy_reply[16]}
  localparam logic [74:0] VECS [6] = '{
    {1'b0, 1'b0, 1'b1, 3'd0, 5'h05, 32'h0000_0003, 16'hA5C3, 16'h0000},
    {1'b0, 1'b1, 1'b1, 3'd3, 5'h1F, 32'h0000_001F, 16'h0000, 16'h1234},
    {1'b0, 1'b0, 1'b0, 3'd2, 5'h00, 32'h0000_0010, 16'hFFFF, 16'h0000},
    {1'b0, 1'b1, 1'b0, 3'd0, 5'h12, 32'h0000_0002, 16'h0000, 16'h8001},
    {1'b1, 1'b0, 1'b1, 3'd1, 5'h03, 32'h0007_BEEF, 16'h5A5A, 16'h0000},
    {1'b1, 1'b1, 1'b0, 3'd3, 5'h09, 32'h001E_0100, 16'h0000, 16'hC0DE}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NB-1:0] mdc, mdo, oe, mdi;
  int checks = 0, errors = 0, cyc = 0;
  int mon_bus = -1, ncap = 0, nfall = 0, viol = 0, hi_run = 0, hi_len = 0;
  logic prev = 1'b0;
  logic [127:0] cap_d = '0, cap_oe = '0;
  logic [15:0] phy_val = '0;

  mdio_mux_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdo),
    .mdio_oe_o(oe), .mdio_i(mdi)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // bus monitor and PHY reply model
  always @(negedge clk) begin
    logic cur;
    int k;
    cur = (mon_bus >= 0) ? mdc[mon_bus] : 1'b0;
    if (cur && !prev) begin
      cap_d  = {cap_d[126:0], mdo[mon_bus]};
      cap_oe = {cap_oe[126:0], oe[mon_bus]};
      ncap++;
    end
    if (!cur && prev) nfall++;
    if (cur) hi_run++;
    else begin
      if (prev) hi_len = hi_run;
      hi_run = 0;
    end
    prev = cur;
    for (int j = 0; j < NB; j++)
      if (j != mon_bus && (mdc[j] || oe[j])) viol++;
    mdi = '1;
    k = nfall % 64;
    if (mon_bus >= 0) mdi[mon_bus] = (k >= 48) ? phy_val[63-k] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic arm(input int bus, input logic [15:0] pv);
    @(negedge clk); #1;
    mon_bus = bus; phy_val = pv; ncap = 0; nfall = 0; viol = 0;
    cap_d = '0; cap_oe = '0; prev = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] d;
    ok = 1'b0;
    for (int n = 0; n < 5000 && !ok; n++) begin
      rreg(A_ST, d);
      ok = d[0];
    end
  endtask

  task automatic run_job(input bit c45, input bit rd, input bit isel, input logic [2:0] bid,
                         input logic [4:0] phy, input logic [31:0] a, input logic [15:0] wd,
                         input logic [15:0] pv, input int bus, input string req);
    bit ok;
    logic [31:0] d;
    logic [63:0] f1, f2, oe2;
    wreg(A_CTL, 32'd0);
    arm(bus, pv);
    wreg(A_PAR, {6'b0, isel, bid, c45, phy, wd});
    wreg(A_ADR, a);
    wreg(A_CTL, rd ? 32'd2 : 32'd1);
    wait_done(ok);
    chk(ok, {req, " R9 done"}, 128'(ok), 128'd1);
    chk(viol == 0, {req, " R3 idle buses"}, 128'(viol), 128'd0);
    if (bus < 0) return;
    oe2 = rd ? RD_OE : ONES;
    if (c45) begin
      f1 = {32'hFFFF_FFFF, 2'b00, 2'b00, phy, a[20:16], 2'b10, a[15:0]};
      f2 = {32'hFFFF_FFFF, 2'b00, rd ? 2'b11 : 2'b01, phy, a[20:16], 2'b10, wd};
      chk(ncap == 128, {req, " R6 bit count"}, 128'(ncap), 128'd128);
      chk(cap_d[127:64] == f1 && cap_oe[127:64] == ONES, {req, " R6 address frame"},
          cap_d[127:64], 128'(f1));
    end else begin
      f2 = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, a[4:0], 2'b10, wd};
      chk(ncap == 64, {req, " R4 bit count"}, 128'(ncap), 128'd64);
    end
    chk(((cap_d[63:0] ^ f2) & oe2) == '0, {req, " R4 frame bits"}, cap_d[63:0], 128'(f2));
    chk(cap_oe[63:0] == oe2, {req, " R5 output enable"}, cap_oe[63:0], 128'(oe2));
    if (rd) begin
      rreg(A_RD, d);
      chk(d == {16'h0, pv}, {req, " R5 read data"}, 128'(d), 128'(pv));
    end
  endtask

  initial begin
    logic [31:0] d;
    bit ok;
    mdi = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    begin
      logic [11:0] regs [8] = '{A_EXT, A_INT, A_SCAN, A_PAR, A_RD, A_ADR, A_CTL, A_ST};
      for (int i = 0; i < 8; i++) begin
        rreg(regs[i], d);
        chk(d == 0, "R1 register reset", 128'(d), 128'd0);
      end
    end
    chk(mdc == '0 && oe == '0, "R1 pins idle", 128'({mdc, oe}), 128'd0);

    // R2 register map and readback
    wreg(A_EXT, 32'hFFFF_FFFF); rreg(A_EXT, d);
    chk(d == 32'h003F_03FF, "R2 rate fields", 128'(d), 128'h003F_03FF);
    wreg(A_SCAN, 32'hFFFF_FFFF); rreg(A_SCAN, d);
    chk(d == 32'h1000_0000, "R2 scan bit", 128'(d), 128'h1000_0000);
    wreg(A_PAR, 32'hDEAD_BEEF); rreg(A_PAR, d);
    chk(d == 32'hDEAD_BEEF, "R2 parameter", 128'(d), 128'hDEAD_BEEF);
    wreg(A_ADR, 32'h1234_5678); rreg(A_ADR, d);
    chk(d == 32'h1234_5678, "R2 address", 128'(d), 128'h1234_5678);
    wreg(A_RD, 32'hFFFF_FFFF); rreg(A_RD, d);
    chk(d == 0, "R2 read data not writable", 128'(d), 128'd0);

    // fastest rate, ownership on
    wreg(A_EXT, 32'h0000_0001);
    wreg(A_INT, 32'h0000_0001);
    wreg(A_SCAN, 32'h1000_0000);

    for (int i = 0; i < 6; i++) begin
      logic [74:0] v;
      v = VECS[i];
      run_job(v[74], v[73], v[72], v[71:69], v[68:64], v[63:32], v[31:16], v[15:0],
              v[72] ? int'(v[71:69]) : NI + int'(v[71:69]), $sformatf("vec%0d", i));
    end

    // R7 internal and external rates are separate
    wreg(A_INT, 32'h0001_0003);
    wreg(A_EXT, 32'h0000_0002);
    run_job(1'b0, 1'b0, 1'b1, 3'd2, 5'h01, 32'h4, 16'h0F0F, 16'h0, 2, "rate_int");
    chk(hi_len == 6, "R7 internal half period", 128'(hi_len), 128'd6);
    run_job(1'b0, 1'b0, 1'b0, 3'd1, 5'h01, 32'h4, 16'h0F0F, 16'h0, NI + 1, "rate_ext");
    chk(hi_len == 2, "R7 external half period", 128'(hi_len), 128'd2);
    wreg(A_INT, 32'h0000_0001);
    wreg(A_EXT, 32'h0000_0001);

    // R3 out-of-range internal id selects nothing
    run_job(1'b0, 1'b0, 1'b1, 3'd5, 5'h01, 32'h1, 16'h1111, 16'h0, -1, "R3 no bus");

    // R10 external pins gated without ownership
    wreg(A_SCAN, 32'h0);
    run_job(1'b0, 1'b0, 1'b0, 3'd1, 5'h02, 32'h1, 16'h2222, 16'h0, -1, "R10 not owned");
    wreg(A_SCAN, 32'h1000_0000);

    // R8 clear, ignored value 3
    wreg(A_CTL, 32'd0); rreg(A_ST, d);
    chk(d[0] == 1'b0, "R8 clear done", 128'(d[0]), 128'd0);
    arm(-1, 16'h0);
    wreg(A_CTL, 32'd3);
    repeat (20) @(negedge clk);
    rreg(A_ST, d);
    chk(d[0] == 1'b0 && viol == 0, "R8 value 3 ignored", 128'(viol), 128'd0);

    // R8 start while busy ignored
    arm(1, 16'h0);
    wreg(A_PAR, {6'b0, 1'b1, 3'd1, 1'b0, 5'h07, 16'h3C3C});
    wreg(A_ADR, 32'h9);
    wreg(A_CTL, 32'd1);
    repeat (10) @(negedge clk);
    wreg(A_CTL, 32'd2);
    wait_done(ok);
    chk(ncap == 64 && cap_oe[63:0] == ONES, "R8 restart ignored", 128'(ncap), 128'd64);
    chk(cap_d[63:0] == {32'hFFFF_FFFF, 4'b0101, 5'h07, 5'h09, 2'b10, 16'h3C3C},
        "R8 frame kept", cap_d[63:0], 128'd0);

    // R9 clear collides with completion
    wreg(A_CTL, 32'd0);
    wreg(A_PAR, {6'b0, 1'b1, 3'd0, 1'b0, 5'h01, 16'h7777});
    wreg(A_CTL, 32'd1);
    begin
      int rises = 0;
      logic pm = 1'b0;
      bit hit = 1'b0;
      for (int n = 0; n < 1000 && !hit; n++) begin
        @(negedge clk); #1;
        if (mdc[0] && !pm) rises++;
        pm = mdc[0];
        if (rises == 64 && mdc[0]) hit = 1'b1;
      end
      wr = 1'b1; addr = A_CTL; wdata = 32'd0;
      @(negedge clk); wr = 1'b0;
      chk(hit, "R9 reached last bit", 128'(rises), 128'd64);
    end
    rreg(A_ST, d);
    chk(d[0] == 1'b1, "R9 completion beats clear", 128'(d[0]), 128'd1);
    wreg(A_CTL, 32'd0); rreg(A_ST, d);
    chk(d[0] == 1'b0, "R8 later clear", 128'(d[0]), 128'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule